// File: doc/BRIEF.md
# Received Frame Buffer with Host Inhibit

This block captures one received radio frame into a 144-byte buffer and lets a host read it back through an address-mapped byte port. The demodulator delivers each frame as a byte stream. The first byte of the stream is flagged as the start of the frame and carries the frame length. That length counts the frame bytes that follow, including the two checksum bytes at the end of the frame, and does not count the length byte itself. After the frame bytes the stream carries one link-quality byte and then one signal-strength byte. The buffer keeps the bytes in this same order. Once the signal-strength byte of an accepted frame has been stored, a receive status bit is set and drives the interrupt line.

The host owns a baseband control register. One bit in that register inhibits reception. While that bit is set, a frame that starts is discarded as a whole. This keeps the buffer contents fixed while the host copies out the previous frame. A frame longer than the buffer can hold is truncated. Its stored length is clamped to match the truncated frame.

Top module: `rxb_frame_buffer`

## Requirements
- R1: After synchronous reset, `rx_irq` is 0, `stat_q` is 0 and `bb_q` is 0.
- R2: Buffer index 0 (host address 0x300) holds the frame length from the start byte, clamped to at most 143. The length excludes the length byte itself.
- R3: Frame bytes, including the two trailing checksum bytes, are stored in arrival order from index 1 (host address 0x301) upward.
- R4: For a frame with stored length Lc, the link-quality byte goes to index Lc+1 and the signal-strength byte to index Lc+2. Any byte whose index would be 144 or more is discarded. For a length above 143, the frame bytes beyond the 143rd are discarded.
- R5: Bit 2 of the baseband register is the inhibit bit, and it is sampled on the start byte. A frame that starts while the bit is 1 writes nothing to the buffer and sets no status. Once the bit is cleared, the next frame is received normally.
- R6: Storing the signal-strength byte of an accepted frame sets bit 3 of `stat_q` and raises `rx_irq` after that clock edge.
- R7: A `stat_rd` pulse clears status bit 3 at the next edge. If a frame completes in the same cycle as the pulse, the bit stays set.
- R8: `host_rd_data` is updated one cycle after `host_rd_en`. For host addresses 0x300 to 0x38F it holds the buffer byte at index (address minus 0x300), and for any other address it holds 0.
- R9: A start byte that arrives in the middle of a frame abandons that frame and begins a new one. The abandoned frame never sets the status bit.
- R10: `bb_q` returns the last value written through `bb_we` and `bb_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_sof | input | 1 | The present byte is the length byte that starts a frame |
| rx_byte | input | 8 | Stream byte |
| host_rd_en | input | 1 | Host buffer read strobe |
| host_addr | input | 10 | Host long address |
| host_rd_data | output | 8 | Read data, valid one cycle after the strobe |
| bb_we | input | 1 | Baseband register write strobe |
| bb_wdata | input | 8 | Baseband register write data (bit 2 = inhibit) |
| bb_q | output | 8 | Baseband register contents |
| stat_rd | input | 1 | Status read, clears the receive bit |
| stat_q | output | 8 | Interrupt status (bit 3 = frame received) |
| rx_irq | output | 1 | Receive interrupt, equal to status bit 3 |

## Verification
Two events can fall on the same clock edge: the host clearing the status by reading it, and the writer setting the status by storing the final byte of a frame. The bench provokes this by pulsing `stat_rd` in exactly the cycle that carries the signal-strength byte. It then expects `rx_irq` to remain 1, because the new frame must not be lost. A second, separate pulse must then clear the bit, which shows that the clear path itself works.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int BUF_DEPTH   = 144;
    localparam int IDX_W       = 8;
    localparam int HOST_ADDR_W = 10;
    localparam int INHIBIT_BIT = 2;
    localparam int RXDONE_BIT  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_QUAL,
        ST_STREN
    } wr_state_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } buf_wr_t;

    function automatic logic [7:0] clamp_len(input logic [7:0] l, input logic [7:0] lim);
        return (l > lim) ? lim : l;
    endfunction

endpackage

// File: rtl/rxb_writer.sv
module rxb_writer
    import rxb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic [7:0] rx_byte,
    input  logic       inhibit,
    output buf_wr_t    wr,
    output logic       frame_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    wr_state_e        state;
    logic [7:0]       remain;
    logic [IDX_W-1:0] wp;
    logic             keep;
    logic             wp_fits;
    logic [IDX_W-1:0] wp_next;

    assign wp_fits = (wp <= LAST_IDX);
    assign wp_next = wp_fits ? wp + 1'b1 : wp;

    always_comb begin
        wr         = '0;
        frame_done = 1'b0;
        if (rx_valid) begin
            if (rx_sof) begin
                wr.en   = !inhibit;
                wr.idx  = '0;
                wr.data = clamp_len(rx_byte, LAST_IDX);
            end else if (state != ST_IDLE && keep) begin
                wr.en      = wp_fits;
                wr.idx     = wp;
                wr.data    = rx_byte;
                frame_done = (state == ST_STREN);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            wp     <= '0;
            keep   <= 1'b0;
        end else if (rx_valid) begin
            if (rx_sof) begin
                remain <= rx_byte;
                wp     <= IDX_W'(1);
                keep   <= !inhibit;
                state  <= (rx_byte == 8'd0) ? ST_QUAL : ST_BODY;
            end else begin
                case (state)
                    ST_BODY: begin
                        wp     <= wp_next;
                        remain <= remain - 8'd1;
                        if (remain == 8'd1) state <= ST_QUAL;
                    end
                    ST_QUAL: begin
                        wp    <= wp_next;
                        state <= ST_STREN;
                    end
                    ST_STREN: state <= ST_IDLE;
                    default:  state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_len_clamped_R2: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx == '0) |-> (wr.data <= LAST_IDX));

    assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(wp) <= DEPTH));

    assert_drop_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (!keep && !rx_sof) |-> !frame_done);

endmodule

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  buf_wr_t          wr,
    input  logic             rd_en,
    input  logic             rd_hit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.idx] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else if (rd_en) rd_data <= rd_hit ? mem[rd_idx] : 8'd0;
    end

    assert_wr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (int'(wr.idx) < DEPTH));

endmodule

// File: rtl/rxb_frame_buffer.sv
module rxb_frame_buffer
    import rxb_pkg::*;
#(
    parameter int                     DEPTH     = BUF_DEPTH,
    parameter int                     ADDR_W    = HOST_ADDR_W,
    parameter logic [ADDR_W-1:0]      BASE_ADDR = 10'h300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_rd_data,
    input  logic              bb_we,
    input  logic [7:0]        bb_wdata,
    output logic [7:0]        bb_q,
    input  logic              stat_rd,
    output logic [7:0]        stat_q,
    output logic              rx_irq
);
    logic [7:0]        bb_reg;
    logic              rx_flag;
    logic              frame_done;
    buf_wr_t           wr;
    logic [ADDR_W-1:0] offset;
    logic              rd_hit;

    always_ff @(posedge clk) begin
        if (rst) bb_reg <= '0;
        else if (bb_we) bb_reg <= bb_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rx_flag <= 1'b0;
        else if (frame_done) rx_flag <= 1'b1;
        else if (stat_rd) rx_flag <= 1'b0;
    end

    assign offset = host_addr - BASE_ADDR;
    assign rd_hit = (host_addr >= BASE_ADDR) && (offset < ADDR_W'(DEPTH));

    always_comb begin
        stat_q             = '0;
        stat_q[RXDONE_BIT] = rx_flag;
    end

    assign bb_q   = bb_reg;
    assign rx_irq = rx_flag;

    rxb_writer #(.DEPTH(DEPTH)) u_writer (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_byte    (rx_byte),
        .inhibit    (bb_reg[INHIBIT_BIT]),
        .wr         (wr),
        .frame_done (frame_done)
    );

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_en   (host_rd_en),
        .rd_hit  (rd_hit),
        .rd_idx  (offset[IDX_W-1:0]),
        .rd_data (host_rd_data)
    );

    assert_done_sets_irq_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> rx_irq);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !frame_done) |=> !rx_irq);

    assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && !rd_hit) |=> (host_rd_data == 8'd0));

endmodule

// File: tb/rxb_frame_buffer_tb.sv
module rxb_frame_buffer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       host_rd_en = 1'b0;
    logic [9:0] host_addr = '0;
    logic [7:0] host_rd_data;
    logic       bb_we = 1'b0;
    logic [7:0] bb_wdata = '0, bb_q, stat_q;
    logic       stat_rd = 1'b0, rx_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rxb_frame_buffer u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .host_rd_en(host_rd_en), .host_addr(host_addr), .host_rd_data(host_rd_data),
        .bb_we(bb_we), .bb_wdata(bb_wdata), .bb_q(bb_q),
        .stat_rd(stat_rd), .stat_q(stat_q), .rx_irq(rx_irq)
    );

    function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + i * 3);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk); host_rd_en = 1'b1; host_addr = a;
        @(negedge clk); host_rd_en = 1'b0; d = host_rd_data;
    endtask

    task automatic send_frame(input logic [7:0] len, input logic [7:0] seed,
                              input logic [7:0] lqi, input logic [7:0] rssi, input bit clr_last);
        @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = len;
        for (int i = 0; i < int'(len); i++) begin
            @(negedge clk); rx_sof = 1'b0; rx_byte = pay(seed, i);
        end
        @(negedge clk); rx_sof = 1'b0; rx_byte = lqi;
        @(negedge clk); rx_byte = rssi; stat_rd = clr_last;
        @(negedge clk); rx_valid = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic write_bb(input logic [7:0] v);
        @(negedge clk); bb_we = 1'b1; bb_wdata = v;
        @(negedge clk); bb_we = 1'b0;
    endtask

    task automatic t_reset();
        chk(32'(rx_irq), 0, "R1 irq after reset");
        chk(32'(stat_q), 0, "R1 status after reset");
        chk(32'(bb_q), 0, "R1 baseband after reset");
    endtask

    task automatic t_normal();
        logic [7:0] d;
        send_frame(8'd5, 8'h10, 8'hA5, 8'h5A, 1'b0);
        chk(32'(rx_irq), 1, "R6 irq after frame");
        chk(32'(stat_q), 32'h08, "R6 status bit 3");
        rd(10'h300, d); chk(32'(d), 5, "R2 length byte");
        for (int i = 0; i < 5; i++) begin
            rd(10'(10'h301 + i), d); chk(32'(d), 32'(pay(8'h10, i)), "R3 frame byte");
        end
        rd(10'h306, d); chk(32'(d), 32'hA5, "R4 quality byte");
        rd(10'h307, d); chk(32'(d), 32'h5A, "R4 strength byte");
        rd(10'h2FF, d); chk(32'(d), 0, "R8 below window");
        rd(10'h390, d); chk(32'(d), 0, "R8 above window");
        clear_status();
        chk(32'(rx_irq), 0, "R7 clear by status read");
    endtask

    task automatic t_empty_and_inhibit();
        logic [7:0] d;
        send_frame(8'd0, 8'h00, 8'h33, 8'h44, 1'b0);
        rd(10'h301, d); chk(32'(d), 32'h33, "R4 quality for zero length");
        rd(10'h302, d); chk(32'(d), 32'h44, "R4 strength for zero length");
        clear_status();
        write_bb(8'h04);
        chk(32'(bb_q), 32'h04, "R10 baseband readback");
        send_frame(8'd3, 8'h77, 8'h99, 8'h88, 1'b0);
        chk(32'(rx_irq), 0, "R5 inhibited frame no irq");
        rd(10'h300, d); chk(32'(d), 0, "R5 length unchanged");
        rd(10'h301, d); chk(32'(d), 32'h33, "R5 buffer unchanged");
        write_bb(8'h00);
        send_frame(8'd2, 8'h50, 8'h61, 8'h62, 1'b0);
        chk(32'(rx_irq), 1, "R5 reception re-enabled");
        rd(10'h300, d); chk(32'(d), 2, "R5 new length stored");
        clear_status();
    endtask

    task automatic t_truncate();
        logic [7:0] d;
        send_frame(8'd200, 8'h01, 8'hEE, 8'hDD, 1'b0);
        chk(32'(rx_irq), 1, "R6 irq for truncated frame");
        rd(10'h300, d); chk(32'(d), 143, "R2 clamped length");
        for (int i = 0; i < 143; i += 13) begin
            rd(10'(10'h301 + i), d); chk(32'(d), 32'(pay(8'h01, i)), "R4 truncated body");
        end
        rd(10'h38F, d); chk(32'(d), 32'(pay(8'h01, 142)), "R4 last slot holds frame byte");
        clear_status();
        send_frame(8'd142, 8'h02, 8'hC1, 8'hC2, 1'b0);
        rd(10'h300, d); chk(32'(d), 142, "R2 length 142");
        rd(10'h38F, d); chk(32'(d), 32'hC1, "R4 quality in last slot");
        clear_status();
    endtask

    task automatic t_abort();
        logic [7:0] d;
        @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'd4;
        @(negedge clk); rx_sof = 1'b0; rx_byte = 8'hF0;
        @(negedge clk); rx_byte = 8'hF1;
        @(negedge clk); rx_valid = 1'b0;
        chk(32'(rx_irq), 0, "R9 partial frame no irq");
        send_frame(8'd1, 8'h40, 8'h11, 8'h22, 1'b0);
        rd(10'h300, d); chk(32'(d), 1, "R9 restarted length");
        rd(10'h301, d); chk(32'(d), 32'h40, "R9 restarted body");
        rd(10'h302, d); chk(32'(d), 32'h11, "R9 restarted quality");
        clear_status();
    endtask

    task automatic t_collide();
        send_frame(8'd3, 8'h08, 8'h01, 8'h02, 1'b1);
        chk(32'(rx_irq), 1, "R7 set wins over same-cycle clear");
        clear_status();
        chk(32'(stat_q), 0, "R7 later clear");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_empty_and_inhibit();
        t_truncate();
        t_abort();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule